// File: doc/BRIEF.md
# Bit Shift Register with Status Flags

This block holds a bit array of up to `MAXW` bits. A signed length input picks how many of the low bits take part. Each rising edge of the enable input moves the active bits one place. A direction input sets which way they move, toward the high end or toward the low end. A single data bit enters the vacated end, and the bit pushed past the other end is kept in an unload flag. Bits above the active length are left alone.

Four status outputs describe the most recent operation:

- An enable flag that follows the enable input.
- A done flag that reports a completed shift.
- An error flag that reports a negative length. When it is set, no shift takes place.
- The unload bit.

A surrounding controller uses the block as a step sequencer or as an item tracker. It raises enable once per event and reads the array bits as outputs.

Top module: `bitshift_reg`

## Requirements
- R1: An active-low reset clears every array bit, the unload bit and the enable, done and error flags to 0.
- R2: A shift occurs only in a clock cycle where enable is 1 and was 0 in the previous cycle. While enable stays high, the array and the unload bit do not change.
- R3: A shift with `dir_right` = 0 and effective length L ≥ 1 has three effects. Bit k moves to bit k+1 for k < L-1. The data bit enters bit 0. The old bit L-1 goes to the unload bit.
- R4: A shift with `dir_right` = 1 and effective length L ≥ 1 has three effects. Bit k moves to bit k-1 for 1 ≤ k ≤ L-1. The data bit enters bit L-1. The old bit 0 goes to the unload bit.
- R5: Array bits at positions L and above keep their values during a shift. A length greater than `MAXW` acts as `MAXW`.
- R6: On an enable rising edge with a negative length (sign bit of `len` set), the error flag becomes 1 and the done flag becomes 0. The array and the unload bit stay unchanged. The error flag keeps its value until the next enable rising edge, which rewrites it from the sign of `len`.
- R7: After a shift that is not in error, the done flag reads 1 from the next clock edge. It returns to 0 at the first clock edge where enable is sampled 0. The enable flag reads the enable input as sampled at the previous clock edge. Done and error are never 1 together.
- R8: A shift with length zero leaves the whole array unchanged and copies the data bit into the unload bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Enable; a 0-to-1 transition requests one shift |
| din | input | 1 | Bit inserted at the entry end |
| dir_right | input | 1 | 0 shifts toward higher indices, 1 toward lower |
| len | input | LW | Signed active length |
| arr | output | MAXW | Bit array |
| en_flag | output | 1 | Enable status |
| done_flag | output | 1 | Shift completed status |
| err_flag | output | 1 | Negative length status |
| unload | output | 1 | Last bit shifted out of range |

## Verification
A broken edge detector shows up on the second cycle of a held enable as an extra movement of `arr`. A wrong length decode shows at once as a change above bit L-1, or as an unload bit taken from the wrong position. An error path that still shifts shows one cycle after the rising edge, as an altered array next to a set error flag. Every such fault is therefore visible at the ports within one or two clocks of the enable edge that exposes it.

// File: rtl/bitshift_reg.sv
module bitshift_reg #(
  parameter int MAXW = 32,
  parameter int LW   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 din,
  input  logic                 dir_right,
  input  logic signed [LW-1:0] len,
  output logic [MAXW-1:0]      arr,
  output logic                 en_flag,
  output logic                 done_flag,
  output logic                 err_flag,
  output logic                 unload
);

  localparam int CW = $clog2(MAXW + 1);

  logic          rise;
  logic          neg;
  logic [CW-1:0] eff_len;
  logic [MAXW-1:0] shl, shr, nxt;
  logic          nul;

  assign rise = en & ~en_flag;
  assign neg  = len[LW-1];
  assign shl  = {arr[MAXW-2:0], din};
  assign shr  = {1'b0, arr[MAXW-1:1]};

  always_comb begin
    int lv;
    lv = int'(len);
    if (lv < 0)         eff_len = '0;
    else if (lv > MAXW) eff_len = CW'(MAXW);
    else                eff_len = CW'(lv);
  end

  always_comb begin
    nxt = arr;
    nul = din;
    if (eff_len != '0) begin
      for (int i = 0; i < MAXW; i++) begin
        if (i < int'(eff_len)) begin
          if (!dir_right) nxt[i] = shl[i];
          else            nxt[i] = (i == int'(eff_len) - 1) ? din : shr[i];
        end
      end
      nul = dir_right ? arr[0] : arr[eff_len - 1'b1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arr       <= '0;
      unload    <= 1'b0;
      en_flag   <= 1'b0;
      done_flag <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      en_flag <= en;
      if (rise) begin
        err_flag <= neg;
        if (neg) begin
          done_flag <= 1'b0;
        end else begin
          arr       <= nxt;
          unload    <= nul;
          done_flag <= 1'b1;
        end
      end else if (!en) begin
        done_flag <= 1'b0;
      end
    end
  end

  a_r2_hold_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (en && en_flag) |=> ($stable(arr) && $stable(unload)));

  a_r3_left_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !neg && !dir_right && eff_len != '0) |=> (arr[0] == $past(din)));

  a_r4_right_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !neg && dir_right && eff_len != '0) |=> (unload == $past(arr[0])));

  a_r6_err_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && neg) |=> (err_flag && !done_flag && $stable(arr) && $stable(unload)));

  a_r7_done_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !done_flag);

  a_r7_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_flag && err_flag));

  a_r8_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && eff_len == '0 && !neg) |=> ($stable(arr) && unload == $past(din)));

endmodule

// File: tb/bitshift_reg_tb.sv
module bitshift_reg_tb_top;
  localparam int MAXW = 8;
  localparam int LW   = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic en = 0, din = 0, dir_right = 0;
  logic signed [LW-1:0] len = '0;
  logic [MAXW-1:0] arr;
  logic en_flag, done_flag, err_flag, unload;

  int checks = 0, errors = 0;
  int m_arr = 0, m_ul = 0, m_err = 0;
  logic [7:0] lfsr = 8'hA5;

  always #2 clk = ~clk;

  bitshift_reg #(.MAXW(MAXW), .LW(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .din(din), .dir_right(dir_right),
    .len(len), .arr(arr), .en_flag(en_flag), .done_flag(done_flag),
    .err_flag(err_flag), .unload(unload));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_shift(int l, bit d, bit r, string req);
    int le, mask, nv;
    @(negedge clk);
    len = LW'(l); din = d; dir_right = r; en = 1;
    if (l < 0) begin
      m_err = 1;
    end else begin
      m_err = 0;
      le = (l > MAXW) ? MAXW : l;
      mask = (1 << le) - 1;
      if (le == 0) begin
        m_ul = d;
      end else if (!r) begin
        m_ul = (m_arr >> (le - 1)) & 1;
        nv = (m_arr << 1) | d;
        m_arr = (m_arr & ~mask) | (nv & mask);
      end else begin
        m_ul = m_arr & 1;
        nv = ((m_arr & mask) >> 1) | (d << (le - 1));
        m_arr = (m_arr & ~mask) | (nv & mask);
      end
    end
    @(posedge clk); #1;
    chk({req, " arr"}, int'(arr), m_arr);
    chk({req, " unload"}, int'(unload), m_ul);
    chk("R6 err", int'(err_flag), m_err);
    chk("R7 done", int'(done_flag), m_err ? 0 : 1);
    chk("R7 en_flag", int'(en_flag), 1);
    @(posedge clk); #1;
    chk("R2 held arr", int'(arr), m_arr);
    chk("R2 held unload", int'(unload), m_ul);
    @(negedge clk); en = 0;
    @(posedge clk); #1;
    chk("R7 done low", int'(done_flag), 0);
    chk("R7 en_flag low", int'(en_flag), 0);
    chk("R6 err kept", int'(err_flag), m_err);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; en = 0;
    @(posedge clk); #1;
    m_arr = 0; m_ul = 0; m_err = 0;
    chk("R1 arr", int'(arr), 0);
    chk("R1 flags", int'({en_flag, done_flag, err_flag, unload}), 0);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    do_reset();
    for (int l = -2; l <= 10; l++) begin
      for (int r = 0; r < 2; r++) begin
        for (int k = 0; k < 10; k++) begin
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          if (l < 0)       do_shift(l, lfsr[0], r[0], "R6");
          else if (l == 0) do_shift(l, lfsr[0], r[0], "R8");
          else if (l > MAXW || l < 4) do_shift(l, lfsr[0], r[0], "R5");
          else if (r == 0) do_shift(l, lfsr[0], r[0], "R3");
          else             do_shift(l, lfsr[0], r[0], "R4");
        end
      end
    end
    for (int k = 0; k < MAXW; k++) do_shift(MAXW, 1'b1, 1'b0, "R3 fill");
    do_shift(3, 1'b0, 1'b1, "R5 upper kept");
    do_shift(-1, 1'b0, 1'b0, "R6 no change");
    do_reset();
    do_shift(1, 1'b1, 1'b0, "R3 after reset");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule